// File: doc/BRIEF.md
# Receive Deserializer with End-of-Frame Gap Detection

This block sits behind a demodulator that delivers one bit time per `bit_tick_i` strobe. On each strobe, `bit_valid_i` reports whether the bit correlated, and `bit_data_i` carries its value. In byte mode, valid bits are collected most-significant first into bytes, and each completed byte lands in a data register that the host reads. In bit-serial mode the block does no assembly. It passes each valid bit straight through on a data/strobe pair.

In either mode, the first valid bit arms a gap counter. Once armed, consecutive bit times without correlated data are counted. When the programmed gap is exceeded, the block declares end of frame. It then moves any partial byte into the data register together with a count of its bits, and drops back to the idle, unarmed state. Status flags for byte-ready and end-of-frame can each be enabled onto one interrupt output. That output can be driven push-pull, inverted push-pull, open-drain or open-source. High-Z is modelled as the output enable being low.

Top module: `rxd_deser`

## Requirements
- R1: Register offsets and reset values. Offset 0 is the control register, reset 0x03. Its bit 3 is the byte-mode enable, bits 2:0 are the gap length L, and bits 7:4 read as zero. Offset 1 is the interrupt configuration register, reset 0x01. Its bits 1:0 are the drive style, bit 4 is the end-of-frame interrupt enable and bit 5 is the byte-ready interrupt enable. Offset 2 is status, reset 0x00. Its bit 0 is byte-ready, bit 1 is end-of-frame and bits 4:2 are the partial bit count. Offset 3 is the data register, reset 0x00.
- R2: With byte mode off, `ser_valid_o` is high in the same cycle as a valid tick and `ser_data_o` follows `bit_data_i`; the data register is not written. With byte mode on, `ser_valid_o` stays low.
- R3: While unarmed (after reset or after an end of frame), invalid ticks never set the end-of-frame flag.
- R4: After arming, end of frame is declared on the (L+1)th consecutive invalid tick.
- R5: With L = 0, end of frame is declared on the first invalid tick after a valid bit.
- R6: A valid tick while armed restarts the gap count from zero without ending the frame.
- R7: Bits enter the byte most-significant first. On the eighth valid bit, the byte is written to the data register, byte-ready is set and the partial count becomes 0.
- R8: At end of frame, the end-of-frame flag is set and the partial count takes the number of bits held (0 to 7). If that count is nonzero, the data register takes those bits right-aligned with zeros above them. The block then returns to unarmed.
- R9: Writing 1 to status bit 0 or bit 1 clears that flag. A flag set in the same cycle as its clear stays set.
- R10: The interrupt is pending when (byte-ready and its enable) or (end-of-frame and its enable).
- R11: Drive styles as (`irq_o`, `irq_oe_o`). Style 11: pending (1,1), idle oe=0. Style 10: pending (0,1), idle oe=0. Style 01: pending (1,1), idle (0,1). Style 00: pending (0,1), idle (1,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle strobe marking a bit time |
| bit_valid_i | input | 1 | Bit correlated in this bit time |
| bit_data_i | input | 1 | Bit value |
| reg_addr_i | input | 2 | Register offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| ser_valid_o | output | 1 | Bit-serial strobe |
| ser_data_o | output | 1 | Bit-serial data |
| irq_o | output | 1 | Interrupt pin value |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
A host write-one-to-clear of byte-ready can land in the same cycle as the eighth valid bit, which sets that flag. The bench drives both in one cycle and expects the flag to survive. A later lone clear is expected to remove it. End of frame and a full byte cannot coincide, because end of frame requires an invalid tick. The table frames check that a full byte is followed by a zero partial count that leaves the data register untouched.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {
    DRV_PP_INV = 2'b00,
    DRV_PP     = 2'b01,
    DRV_OD     = 2'b10,
    DRV_OS     = 2'b11
  } irq_drv_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_ICFG = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;
endpackage

// File: rtl/rxd_gap_timer.sv
module rxd_gap_timer #(
  parameter int GAP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             valid_i,
  input  logic [GAP_W-1:0] gap_len_i,
  output logic             armed_o,
  output logic [GAP_W-1:0] gap_cnt_o,
  output logic             eof_o
);
  logic             armed_q;
  logic [GAP_W-1:0] cnt_q;

  // >= so that a length lowered mid-gap still terminates
  assign eof_o     = tick_i && !valid_i && armed_q && (cnt_q >= gap_len_i);
  assign armed_o   = armed_q;
  assign gap_cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (valid_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (eof_o) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (armed_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxd_assembler.sv
module rxd_assembler #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              flush_i,
  output logic              full_o,
  output logic              part_o,
  output logic [DATA_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign full_o = shift_i && (cnt_q == LAST);
  assign part_o = flush_i && (cnt_q != '0);
  assign cnt_o  = full_o ? '0 : cnt_q;
  assign word_o = full_o ? {sh_q[DATA_W-2:0], bit_i} : sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (full_o || flush_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[DATA_W-2:0], bit_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rxd_irq_drv.sv
module rxd_irq_drv
  import rxd_pkg::*;
(
  input  irq_drv_e style_i,
  input  logic     pend_i,
  output logic     pin_o,
  output logic     oe_o
);
  always_comb begin
    unique case (style_i)
      DRV_OS:     begin pin_o = 1'b1;    oe_o = pend_i; end
      DRV_OD:     begin pin_o = 1'b0;    oe_o = pend_i; end
      DRV_PP:     begin pin_o = pend_i;  oe_o = 1'b1;   end
      default:    begin pin_o = !pend_i; oe_o = 1'b1;   end
    endcase
  end
endmodule

// File: rtl/rxd_deser.sv
module rxd_deser
  import rxd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GAP_W  = 3,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              bit_valid_i,
  input  logic              bit_data_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              ser_valid_o,
  output logic              ser_data_o,
  output logic              irq_o,
  output logic              irq_oe_o
);
  localparam int EOF_IE_BIT  = 4;
  localparam int BYTE_IE_BIT = 5;
  localparam int CNT_LSB     = 2;

  logic             byte_en_q;
  logic [GAP_W-1:0] gap_len_q;
  irq_drv_e         style_q;
  logic             eof_ie_q, byte_ie_q;
  logic             rdy_q, eof_q;
  logic [CNT_W-1:0] part_cnt_q;
  logic [DATA_W-1:0] data_q;

  logic             armed_w, eof_w, full_w, part_w, pend_w;
  logic [GAP_W-1:0] gap_cnt_w;
  logic [DATA_W-1:0] word_w;
  logic [CNT_W-1:0] cnt_w;
  logic             valid_tick, wr_ctrl, wr_icfg, wr_stat;

  assign valid_tick = bit_tick_i && bit_valid_i;
  assign wr_ctrl    = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_icfg    = reg_we_i && (reg_addr_i == ADDR_ICFG);
  assign wr_stat    = reg_we_i && (reg_addr_i == ADDR_STAT);

  assign ser_valid_o = valid_tick && !byte_en_q;
  assign ser_data_o  = ser_valid_o && bit_data_i;

  rxd_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (bit_tick_i),
    .valid_i   (bit_valid_i),
    .gap_len_i (gap_len_q),
    .armed_o   (armed_w),
    .gap_cnt_o (gap_cnt_w),
    .eof_o     (eof_w)
  );

  rxd_assembler #(.DATA_W(DATA_W)) u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (valid_tick && byte_en_q),
    .bit_i   (bit_data_i),
    .flush_i (eof_w),
    .full_o  (full_w),
    .part_o  (part_w),
    .word_o  (word_w),
    .cnt_o   (cnt_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_en_q <= 1'b0;
      gap_len_q <= GAP_W'(3);
      style_q   <= DRV_PP;
      eof_ie_q  <= 1'b0;
      byte_ie_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        gap_len_q <= reg_wdata_i[GAP_W-1:0];
        byte_en_q <= reg_wdata_i[GAP_W];
      end
      if (wr_icfg) begin
        style_q   <= irq_drv_e'(reg_wdata_i[1:0]);
        eof_ie_q  <= reg_wdata_i[EOF_IE_BIT];
        byte_ie_q <= reg_wdata_i[BYTE_IE_BIT];
      end
    end
  end

  // set has priority over a same-cycle write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q      <= 1'b0;
      eof_q      <= 1'b0;
      part_cnt_q <= '0;
      data_q     <= '0;
    end else begin
      rdy_q <= full_w || (rdy_q && !(wr_stat && reg_wdata_i[0]));
      eof_q <= eof_w  || (eof_q && !(wr_stat && reg_wdata_i[1]));
      if (full_w || eof_w) part_cnt_q <= cnt_w;
      if (full_w || part_w) data_q <= word_w;
    end
  end

  assign pend_w = (rdy_q && byte_ie_q) || (eof_q && eof_ie_q);

  rxd_irq_drv u_irq (
    .style_i (style_q),
    .pend_i  (pend_w),
    .pin_o   (irq_o),
    .oe_o    (irq_oe_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: begin
        reg_rdata_o[GAP_W-1:0] = gap_len_q;
        reg_rdata_o[GAP_W]     = byte_en_q;
      end
      ADDR_ICFG: begin
        reg_rdata_o[1:0]         = style_q;
        reg_rdata_o[EOF_IE_BIT]  = eof_ie_q;
        reg_rdata_o[BYTE_IE_BIT] = byte_ie_q;
      end
      ADDR_STAT: begin
        reg_rdata_o[0] = rdy_q;
        reg_rdata_o[1] = eof_q;
        reg_rdata_o[CNT_LSB +: CNT_W] = part_cnt_q;
      end
      default: reg_rdata_o = data_q;
    endcase
  end
endmodule

// File: rtl/rxd_deser_chk.sv
module rxd_deser_chk #(
  parameter int GAP_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_tick_i,
  input logic             bit_valid_i,
  input logic             byte_en_i,
  input logic [GAP_W-1:0] gap_len_i,
  input logic             armed_i,
  input logic [GAP_W-1:0] gap_cnt_i,
  input logic             eof_i,
  input logic             eof_flag_i,
  input logic             ser_valid_i
);
  AST_IDLE_NO_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_i && bit_tick_i && !bit_valid_i && !eof_flag_i) |=> !eof_flag_i); // R3
  AST_EOF_ON_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_i |-> (bit_tick_i && !bit_valid_i)); // R4
  AST_ZERO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && gap_len_i == '0 && bit_tick_i && !bit_valid_i) |-> eof_i); // R5
  AST_VALID_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_i && bit_valid_i) |=> (armed_i && gap_cnt_i == '0)); // R6
  AST_EOF_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_i |=> (!armed_i && eof_flag_i)); // R8
  AST_SERIAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_en_i |-> !ser_valid_i); // R2
endmodule

bind rxd_deser rxd_deser_chk #(.GAP_W(GAP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_tick_i  (bit_tick_i),
  .bit_valid_i (bit_valid_i),
  .byte_en_i   (byte_en_q),
  .gap_len_i   (gap_len_q),
  .armed_i     (armed_w),
  .gap_cnt_i   (gap_cnt_w),
  .eof_i       (eof_w),
  .eof_flag_i  (eof_q),
  .ser_valid_i (ser_valid_o)
);

// File: tb/rxd_deser_test.sv
`timescale 1ns/1ps
module rxd_deser_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_tick_i = 1'b0, bit_valid_i = 1'b0, bit_data_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       ser_valid_o, ser_data_o, irq_o, irq_oe_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk_i = !clk_i;

  rxd_deser uut (.*);

  typedef struct packed {
    logic [2:0]  gap;
    logic [3:0]  nbits;
    logic [15:0] pat;
    logic [7:0]  exp_data;
    logic [2:0]  exp_cnt;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{3'd0, 4'd3,  16'h0005, 8'h05, 3'd5 - 3'd2},
    '{3'd3, 4'd8,  16'h00A5, 8'hA5, 3'd0},
    '{3'd7, 4'd5,  16'h0013, 8'h13, 3'd5},
    '{3'd2, 4'd11, 16'h065A, 8'h02, 3'd3},
    '{3'd1, 4'd1,  16'h0001, 8'h01, 3'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; #1;
    d = reg_rdata_o;
  endtask

  task automatic tk(input logic v, input logic b);
    @(negedge clk_i);
    bit_tick_i = 1'b1; bit_valid_i = v; bit_data_i = b;
    @(posedge clk_i); #1;
    bit_tick_i = 1'b0; bit_valid_i = 1'b0; bit_data_i = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r, d0;
    int eof_at;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // reset state
    rd(2'd0, r); chk("R1 ctrl reset", r, 8'h03);
    rd(2'd1, r); chk("R1 icfg reset", r, 8'h01);
    rd(2'd2, r); chk("R1 status reset", r, 8'h00);
    rd(2'd3, r); chk("R1 data reset", r, 8'h00);
    chk("R11 idle push-pull pin", {irq_o, irq_oe_o}, 2'b01);
    wr(2'd0, 8'hFF);
    rd(2'd0, r); chk("R1 reserved bits read zero", r, 8'h0F);

    // R3: unarmed invalid ticks never end a frame
    wr(2'd0, 8'h08);
    for (int i = 0; i < 20; i++) tk(1'b0, 1'b0);
    rd(2'd2, r); chk("R3 no eof while unarmed", r[1], 0);

    // table of frames
    foreach (VEC[e]) begin
      wr(2'd0, 8'h08 | 8'(VEC[e].gap));
      wr(2'd1, 8'h31);
      wr(2'd2, 8'h03);
      for (int i = 15; i >= 0; i--)
        if (i < int'(VEC[e].nbits)) tk(1'b1, VEC[e].pat[i]);
      eof_at = -1;
      for (int k = 0; k <= int'(VEC[e].gap); k++) begin
        tk(1'b0, 1'b0);
        rd(2'd2, r);
        if (r[1] && eof_at < 0) eof_at = k;
      end
      chk(VEC[e].gap == 0 ? "R5 eof on first invalid" : "R4 eof after L+1 invalid",
          eof_at, VEC[e].gap);
      rd(2'd2, r);
      chk("R8 partial count", r[4:2], VEC[e].exp_cnt);
      chk("R7 byte ready", r[0], VEC[e].nbits >= 8);
      rd(2'd3, r);
      chk("R7 R8 data register", r, VEC[e].exp_data);
      chk("R10 irq pending", {irq_o, irq_oe_o}, 2'b11);
    end

    // R3 after an eof: back to unarmed
    wr(2'd2, 8'h03);
    for (int i = 0; i < 10; i++) tk(1'b0, 1'b0);
    rd(2'd2, r); chk("R3 unarmed after eof", r[1], 0);

    // R6: valid bit inside the gap restarts the count
    wr(2'd0, 8'h0A);
    tk(1'b1, 1'b1); tk(1'b1, 1'b0);
    tk(1'b0, 1'b0); tk(1'b0, 1'b0);
    tk(1'b1, 1'b1);
    tk(1'b0, 1'b0); tk(1'b0, 1'b0);
    rd(2'd2, r); chk("R6 gap restarted, no eof", r[1], 0);
    tk(1'b0, 1'b0);
    rd(2'd2, r); chk("R6 eof after restarted gap", r[1], 1);
    chk("R6 R8 count", r[4:2], 3);
    rd(2'd3, r); chk("R6 R8 data", r, 8'h05);

    // R10 / R11: enable and drive styles
    wr(2'd1, 8'h01);
    chk("R10 disabled source not pending", {irq_o, irq_oe_o}, 2'b01);
    for (int s = 0; s < 4; s++) begin
      wr(2'd1, 8'h10 | 8'(s));
      #1;
      case (s)
        0: chk("R11 style00 asserted", {irq_o, irq_oe_o}, 2'b01);
        1: chk("R11 style01 asserted", {irq_o, irq_oe_o}, 2'b11);
        2: chk("R11 style10 asserted", {irq_o, irq_oe_o}, 2'b01);
        default: chk("R11 style11 asserted", {irq_o, irq_oe_o}, 2'b11);
      endcase
    end
    wr(2'd2, 8'h03);
    for (int s = 0; s < 4; s++) begin
      wr(2'd1, 8'h10 | 8'(s));
      #1;
      case (s)
        0: chk("R11 style00 idle", {irq_o, irq_oe_o}, 2'b11);
        1: chk("R11 style01 idle", {irq_o, irq_oe_o}, 2'b01);
        2: chk("R11 style10 idle oe", irq_oe_o, 0);
        default: chk("R11 style11 idle oe", irq_oe_o, 0);
      endcase
    end

    // R2: bit-serial pass-through
    rd(2'd3, d0);
    wr(2'd0, 8'h03);
    @(negedge clk_i);
    bit_tick_i = 1'b1; bit_valid_i = 1'b1; bit_data_i = 1'b1; #1;
    chk("R2 serial strobe", ser_valid_o, 1);
    chk("R2 serial data", ser_data_o, 1);
    @(posedge clk_i); #1;
    bit_tick_i = 1'b0; bit_valid_i = 1'b0; bit_data_i = 1'b0;
    for (int i = 0; i < 4; i++) tk(1'b0, 1'b0);
    rd(2'd2, r); chk("R2 eof in serial mode", r[1], 1);
    chk("R2 serial count zero", r[4:2], 0);
    rd(2'd3, r); chk("R2 data untouched in serial mode", r, d0);
    wr(2'd0, 8'h0B);
    @(negedge clk_i);
    bit_tick_i = 1'b1; bit_valid_i = 1'b1; bit_data_i = 1'b1; #1;
    chk("R2 strobe quiet in byte mode", ser_valid_o, 0);
    @(posedge clk_i); #1;
    bit_tick_i = 1'b0; bit_valid_i = 1'b0; bit_data_i = 1'b0;
    for (int i = 0; i < 4; i++) tk(1'b0, 1'b0);

    // R9: clear and set in the same cycle
    wr(2'd0, 8'h0F);
    wr(2'd2, 8'h03);
    for (int i = 0; i < 7; i++) tk(1'b1, 1'b0);
    @(negedge clk_i);
    bit_tick_i = 1'b1; bit_valid_i = 1'b1; bit_data_i = 1'b1;
    reg_addr_i = 2'd2; reg_wdata_i = 8'h01; reg_we_i = 1'b1;
    @(posedge clk_i); #1;
    bit_tick_i = 1'b0; bit_valid_i = 1'b0; bit_data_i = 1'b0; reg_we_i = 1'b0;
    rd(2'd2, r); chk("R9 set wins over clear", r[0], 1);
    rd(2'd3, r); chk("R7 msb-first byte", r, 8'h01);
    wr(2'd2, 8'h01);
    rd(2'd2, r); chk("R9 lone clear", r[0], 0);
    for (int i = 0; i < 8; i++) tk(1'b0, 1'b0);
    rd(2'd2, r); chk("R8 eof with empty partial", r[4:1], 4'b0001);
    rd(2'd3, r); chk("R8 empty partial keeps data", r, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule